// File: doc/BRIEF.md
# Prioritized Interrupt Resolver

This block arbitrates eight interrupt request lines for a processor. Each line can be captured on its rising edge or followed as a level, and any line can be disabled through an eight-bit mask. The block tracks which sources are currently being serviced. It raises `int_req` only when the best enabled request outranks every source in service. An acknowledge, or a poll, hands over the winner. In the same cycle it returns an eight-bit vector made of a programmable base and the winning input index.

Service ends through end-of-interrupt commands. These can clear the highest-ranked in-service source or a named one, and can optionally rotate priority so that the finished source drops to lowest rank. An automatic mode instead retires the source at acknowledge time, and that mode can also rotate. A special mask mode lets a masked source that is in service stop blocking lower-ranked requests. All configuration arrives as already-decoded fields from a separate command interface.

Top module: `irq_resolver`

## Requirements
- R1: After reset, `int_req` is low and `poll_data` is 0. No source is in service, the mask enables all eight inputs, and input 0 ranks highest down to input 7 lowest.
- R2: With `cfg_level` = 0, a request is latched on a 0-to-1 transition of its input line and stays latched after the line falls, until it is acknowledged.
- R3: With `cfg_level` = 1, a request is present exactly while its line is high, in the same cycle, and an acknowledge does not remove it.
- R4: Mask bit n = 1 disables input n and 0 enables it; `mask_we` loads `mask_wdata`. Masking never discards a latched request, which is served once unmasked.
- R5: `int_req` is high only when the highest-ranked enabled request ranks strictly above every in-service source. A source of equal or lower rank waits until that service ends.
- R6: When `int_ack` is high while `int_req` is high, `vec_out` = {`cfg_vec_base`, 3-bit winner index} in that cycle. The winner then enters service, and in edge mode its latched request is cleared.
- R7: An acknowledge or poll while `int_req` is low changes no state.
- R8: `cmd_op` 1 clears the highest-ranked in-service source; `cmd_op` 2 clears the source named by `cmd_idx`.
- R9: With `cfg_auto_eoi` = 1, an acknowledge does not place the winner in service.
- R10: `cmd_op` 3 and 4 act as 1 and 2 and also make the cleared source lowest rank. `cmd_op` 5 makes `cmd_idx` lowest rank, so `cmd_idx`+1 (mod 8) ranks highest. `cmd_op` 6 and 7 turn on and off rotation in automatic mode, where each acknowledged source becomes lowest rank. `cmd_op` 0 does nothing.
- R11: With `cfg_special_mask` = 1, a masked in-service source does not block lower-ranked requests.
- R12: `poll_data` is {1, 0000, winner index} while `int_req` is high and 0 otherwise. A `poll` pulse acts as an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 8 | Request lines, bit n is input n |
| cfg_level | input | 1 | 1 = level-sensitive, 0 = rising-edge capture |
| cfg_auto_eoi | input | 1 | 1 = retire service at acknowledge |
| cfg_special_mask | input | 1 | 1 = masked in-service sources do not block |
| cfg_vec_base | input | 5 | Upper five bits of the returned vector |
| mask_we | input | 1 | Load the mask register |
| mask_wdata | input | 8 | New mask value, 1 = disabled |
| cmd_valid | input | 1 | End-of-interrupt or priority command strobe |
| cmd_op | input | 3 | Command code, see R8 and R10 |
| cmd_idx | input | 3 | Input index named by a command |
| int_ack | input | 1 | Single-cycle acknowledge from the processor |
| poll | input | 1 | Single-cycle poll, also an acknowledge |
| int_req | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector number for the current winner |
| poll_data | output | 8 | Poll result word |

## Verification
The bound checker watches every cycle for four things. The winner must be a single enabled, present request that is not itself in service. Service state may move only on an acknowledge or a command, and an accepted acknowledge must add the winner to service unless automatic mode is on. A non-specific end of interrupt must remove exactly one in-service source. Rank rotation cannot be seen by those properties. The same holds for edge-versus-level capture, requests held through masking, special mask mode and the poll word; the bench's directed sequences and a reference model driven with random traffic show these.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the interrupt resolver.
// Assumes: command codes are decoded upstream into a 3-bit field.
package irq_pkg;

    typedef enum logic [2:0] {
        OP_NOP          = 3'd0,
        OP_EOI_TOP      = 3'd1,
        OP_EOI_IDX      = 3'd2,
        OP_EOI_TOP_ROT  = 3'd3,
        OP_EOI_IDX_ROT  = 3'd4,
        OP_SET_LOWEST   = 3'd5,
        OP_AUTO_ROT_ON  = 3'd6,
        OP_AUTO_ROT_OFF = 3'd7
    } irq_op_e;

endpackage

// File: rtl/irq_req_latch.sv
`timescale 1ns/1ps
// Request capture stage: one slice per input line.
// Edge mode latches a rising edge until the winner is acknowledged;
// level mode passes the line straight through and keeps the latch empty.
// Assumes: lines are already synchronous to clk.
module irq_req_latch #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] line_i,
    input  logic             level_i,
    input  logic [N_SRC-1:0] take_oh_i,
    output logic [N_SRC-1:0] req_o
);

    for (genvar g = 0; g < N_SRC; g++) begin : g_slice
        logic prev_q;
        logic held_q;

        // Track the previous line value and the latched edge request.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                held_q <= 1'b0;
            end else begin
                prev_q <= line_i[g];
                if (level_i)
                    held_q <= 1'b0;
                else if (line_i[g] && !prev_q)
                    held_q <= 1'b1;
                else if (take_oh_i[g])
                    held_q <= 1'b0;
            end
        end

        // Present either the live line or the latched edge.
        assign req_o[g] = level_i ? line_i[g] : held_q;
    end

endmodule

// File: rtl/irq_prio_rank.sv
`timescale 1ns/1ps
// Rotating priority encoder.
// Rank 0 is the input just above low_i (mod N_SRC); returns the best rank set.
// Assumes: N_SRC is a power of two so index arithmetic wraps naturally.
module irq_prio_rank #(
    parameter int N_SRC = 8,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] vec_i,
    input  logic [IDX_W-1:0] low_i,
    output logic             any_o,
    output logic [IDX_W-1:0] rank_o
);

    // Scan from worst rank to best so the best hit is the last assignment.
    always_comb begin
        logic [IDX_W-1:0] cand;
        any_o  = 1'b0;
        rank_o = '0;
        for (int r = N_SRC - 1; r >= 0; r--) begin
            cand = low_i + IDX_W'(r + 1);
            if (vec_i[cand]) begin
                any_o  = 1'b1;
                rank_o = IDX_W'(r);
            end
        end
    end

endmodule

// File: rtl/irq_isr_ctrl.sv
`timescale 1ns/1ps
// In-service register, lowest-rank pointer and automatic-rotation flag.
// Applies acknowledges and decoded end-of-interrupt / priority commands.
// Assumes: take_oh_i is one-hot or zero and matches take_idx_i.
module irq_isr_ctrl
    import irq_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic [N_SRC-1:0] take_oh_i,
    input  logic [IDX_W-1:0] take_idx_i,
    input  logic             auto_eoi_i,
    input  logic             cmd_valid_i,
    input  irq_op_e          cmd_op_i,
    input  logic [IDX_W-1:0] cmd_idx_i,
    output logic [N_SRC-1:0] isr_o,
    output logic [IDX_W-1:0] low_o
);

    logic [N_SRC-1:0] isr_q;
    logic [IDX_W-1:0] low_q;
    logic             auto_rot_q;
    logic             top_any;
    logic [IDX_W-1:0] top_rank;
    logic [IDX_W-1:0] top_idx;
    logic [N_SRC-1:0] clr_oh;
    logic             load_low;
    logic [IDX_W-1:0] next_low;

    irq_prio_rank #(.N_SRC(N_SRC)) u_top_rank (
        .vec_i  (isr_q),
        .low_i  (low_q),
        .any_o  (top_any),
        .rank_o (top_rank)
    );

    // Convert the best in-service rank back to an input index.
    assign top_idx = low_q + top_rank + IDX_W'(1);

    // Decode the command into a clear mask and an optional pointer load.
    always_comb begin
        clr_oh   = '0;
        load_low = 1'b0;
        next_low = low_q;
        if (cmd_valid_i) begin
            unique case (cmd_op_i)
                OP_EOI_TOP: begin
                    if (top_any) clr_oh = N_SRC'(1) << top_idx;
                end
                OP_EOI_TOP_ROT: begin
                    if (top_any) begin
                        clr_oh   = N_SRC'(1) << top_idx;
                        load_low = 1'b1;
                        next_low = top_idx;
                    end
                end
                OP_EOI_IDX: begin
                    clr_oh = N_SRC'(1) << cmd_idx_i;
                end
                OP_EOI_IDX_ROT: begin
                    clr_oh   = N_SRC'(1) << cmd_idx_i;
                    load_low = 1'b1;
                    next_low = cmd_idx_i;
                end
                OP_SET_LOWEST: begin
                    load_low = 1'b1;
                    next_low = cmd_idx_i;
                end
                default: ;
            endcase
        end
    end

    // Update service bits, rotation flag and lowest-rank pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q      <= '0;
            low_q      <= IDX_W'(N_SRC - 1);
            auto_rot_q <= 1'b0;
        end else begin
            isr_q <= (isr_q | ((take_i && !auto_eoi_i) ? take_oh_i : '0)) & ~clr_oh;
            if (cmd_valid_i && cmd_op_i == OP_AUTO_ROT_ON)
                auto_rot_q <= 1'b1;
            else if (cmd_valid_i && cmd_op_i == OP_AUTO_ROT_OFF)
                auto_rot_q <= 1'b0;
            if (load_low)
                low_q <= next_low;
            else if (take_i && auto_eoi_i && auto_rot_q)
                low_q <= take_idx_i;
        end
    end

    assign isr_o = isr_q;
    assign low_o = low_q;

endmodule

// File: rtl/irq_resolver.sv
`timescale 1ns/1ps
// Prioritized interrupt resolver: capture, mask, rank against in-service
// sources, hand over the winner on acknowledge or poll.
// Assumes: int_ack and poll are single-cycle pulses; config is static
// around acknowledges.
module irq_resolver
    import irq_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int VEC_W = 8,
    localparam int IDX_W  = $clog2(N_SRC),
    localparam int BASE_W = VEC_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_in,
    input  logic              cfg_level,
    input  logic              cfg_auto_eoi,
    input  logic              cfg_special_mask,
    input  logic [BASE_W-1:0] cfg_vec_base,
    input  logic              mask_we,
    input  logic [N_SRC-1:0]  mask_wdata,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic              int_ack,
    input  logic              poll,
    output logic              int_req,
    output logic [VEC_W-1:0]  vec_out,
    output logic [VEC_W-1:0]  poll_data
);

    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] req_raw;
    logic [N_SRC-1:0] req_elig;
    logic [N_SRC-1:0] isr_w;
    logic [N_SRC-1:0] blk_vec;
    logic [N_SRC-1:0] win_oh;
    logic [IDX_W-1:0] low_w;
    logic [IDX_W-1:0] req_rank;
    logic [IDX_W-1:0] blk_rank;
    logic [IDX_W-1:0] win_idx;
    logic             req_any;
    logic             blk_any;
    logic             take;

    // Hold the source mask.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (mask_we)
            mask_q <= mask_wdata;
    end

    irq_req_latch #(.N_SRC(N_SRC)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_i    (irq_in),
        .level_i   (cfg_level),
        .take_oh_i (win_oh & {N_SRC{take}}),
        .req_o     (req_raw)
    );

    // Enabled requests and the in-service set that may block them.
    assign req_elig = req_raw & ~mask_q;
    assign blk_vec  = cfg_special_mask ? (isr_w & ~mask_q) : isr_w;

    irq_prio_rank #(.N_SRC(N_SRC)) u_req_rank (
        .vec_i  (req_elig),
        .low_i  (low_w),
        .any_o  (req_any),
        .rank_o (req_rank)
    );

    irq_prio_rank #(.N_SRC(N_SRC)) u_blk_rank (
        .vec_i  (blk_vec),
        .low_i  (low_w),
        .any_o  (blk_any),
        .rank_o (blk_rank)
    );

    // Winner must strictly outrank all blocking service.
    assign int_req = req_any && (!blk_any || (req_rank < blk_rank));
    assign win_idx = low_w + req_rank + IDX_W'(1);
    assign win_oh  = int_req ? (N_SRC'(1) << win_idx) : '0;
    assign take    = (int_ack || poll) && int_req;

    irq_isr_ctrl #(.N_SRC(N_SRC)) u_isr (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_i      (take),
        .take_oh_i   (win_oh),
        .take_idx_i  (win_idx),
        .auto_eoi_i  (cfg_auto_eoi),
        .cmd_valid_i (cmd_valid),
        .cmd_op_i    (irq_op_e'(cmd_op)),
        .cmd_idx_i   (cmd_idx),
        .isr_o       (isr_w),
        .low_o       (low_w)
    );

    // Vector and poll word for the current winner.
    assign vec_out   = {cfg_vec_base, win_idx};
    assign poll_data = int_req ? {1'b1, {(VEC_W-1-IDX_W){1'b0}}, win_idx} : '0;

endmodule

// File: rtl/irq_resolver_chk.sv
`timescale 1ns/1ps
// Cycle checker for irq_resolver, attached by bind.
// Assumes: synchronous active-low reset shared with the design.
module irq_resolver_chk #(
    parameter int N_SRC = 8,
    parameter int VEC_W = 8,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             int_req,
    input logic             int_ack,
    input logic             poll,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic             cfg_auto_eoi,
    input logic             cfg_special_mask,
    input logic [N_SRC-1:0] mask_q,
    input logic [N_SRC-1:0] req_raw,
    input logic [N_SRC-1:0] isr_w,
    input logic [N_SRC-1:0] win_oh
);

    logic take_c;
    assign take_c = (int_ack || poll) && int_req;

    AST_WIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_oh)); // R5
    AST_WIN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> ((win_oh & mask_q) == '0 && (win_oh & req_raw) != '0)); // R4
    AST_WIN_NOT_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && !cfg_special_mask) |-> ((win_oh & isr_w) == '0)); // R5
    AST_ACK_ENTERS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (take_c && !cfg_auto_eoi && !cmd_valid) |=> ((isr_w & $past(win_oh)) != '0)); // R6
    AST_AUTO_EOI_NO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (take_c && cfg_auto_eoi && !cmd_valid) |=> (isr_w == $past(isr_w))); // R9
    AST_IDLE_SERVICE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_c && !cmd_valid) |=> $stable(isr_w)); // R7
    AST_TOP_EOI_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd1 && !take_c) |=>
        ($countones(isr_w) + int'($past(isr_w) != '0) == $countones($past(isr_w)))); // R8

endmodule

bind irq_resolver irq_resolver_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .int_req          (int_req),
    .int_ack          (int_ack),
    .poll             (poll),
    .cmd_valid        (cmd_valid),
    .cmd_op           (cmd_op),
    .cfg_auto_eoi     (cfg_auto_eoi),
    .cfg_special_mask (cfg_special_mask),
    .mask_q           (mask_q),
    .req_raw          (req_raw),
    .isr_w            (isr_w),
    .win_oh           (win_oh)
);

// File: tb/irq_resolver_tb_top.sv
`timescale 1ns/1ps
// Bench: directed corner cases then seeded random traffic, all compared
// against a requirement-level model of the resolver.
module irq_resolver_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq = '0;
    logic       cfg_level = 1'b0;
    logic       cfg_auto_eoi = 1'b0;
    logic       cfg_special_mask = 1'b0;
    logic [4:0] cfg_vec_base = 5'h0A;
    logic       mask_we = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [2:0] cmd_idx = '0;
    logic       int_ack = 1'b0;
    logic       poll = 1'b0;
    logic       int_req;
    logic [7:0] vec_out;
    logic [7:0] poll_data;

    int tests = 0;
    int fails = 0;

    // Model state
    logic [7:0] m_irr = '0, m_isr = '0, m_mask = '0, m_prev = '0;
    logic [2:0] m_low = 3'd7;
    bit         m_rot = 1'b0;

    always #2.5 clk = ~clk;

    irq_resolver dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq), .cfg_level(cfg_level),
        .cfg_auto_eoi(cfg_auto_eoi), .cfg_special_mask(cfg_special_mask),
        .cfg_vec_base(cfg_vec_base), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
        .int_ack(int_ack), .poll(poll), .int_req(int_req),
        .vec_out(vec_out), .poll_data(poll_data)
    );

    function automatic int top_of(logic [7:0] v, logic [2:0] low);
        for (int r = 0; r < 8; r++) begin
            int i = (int'(low) + 1 + r) % 8;
            if (v[i]) return i;
        end
        return -1;
    endfunction

    function automatic int rank_of(int i, logic [2:0] low);
        return (i - int'(low) - 1 + 16) % 8;
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp,
                       input string tag, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %02h expected %02h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Concrete expectation for the current cycle, without advancing.
    task automatic peek(input string tag, input bit exp_req, input logic [7:0] exp_vec);
        #0.2;
        chk({7'd0, int_req}, {7'd0, exp_req}, tag, "int_req");
        if (exp_req) chk(vec_out, exp_vec, tag, "vec_out");
    endtask

    // Compare with the model, advance model and design by one cycle.
    task automatic step(input string tag);
        logic [7:0] elig, blk, nisr, clr;
        logic [2:0] nlow;
        int w, b, ti;
        bit ereq, fire;
        #0.2;
        elig = (cfg_level ? irq : m_irr) & ~m_mask;
        blk  = cfg_special_mask ? (m_isr & ~m_mask) : m_isr;
        w = top_of(elig, m_low);
        b = top_of(blk, m_low);
        ereq = (w >= 0) && (b < 0 || rank_of(w, m_low) < rank_of(b, m_low));
        chk({7'd0, int_req}, {7'd0, ereq}, tag, "model int_req");
        if (ereq) chk(vec_out, {cfg_vec_base, 3'(w)}, tag, "model vec_out");
        chk(poll_data, ereq ? {5'b10000, 3'(w)} : 8'h00, tag, "model poll_data");
        fire = (int_ack || poll) && ereq;
        nisr = m_isr; nlow = m_low; clr = '0;
        if (fire) begin
            if (!cfg_auto_eoi) nisr[w] = 1'b1;
            else if (m_rot) nlow = 3'(w);
        end
        if (cmd_valid) begin
            ti = top_of(m_isr, m_low);
            case (cmd_op)
                3'd1: if (ti >= 0) clr[ti] = 1'b1;
                3'd2: clr[cmd_idx] = 1'b1;
                3'd3: if (ti >= 0) begin clr[ti] = 1'b1; nlow = 3'(ti); end
                3'd4: begin clr[cmd_idx] = 1'b1; nlow = cmd_idx; end
                3'd5: nlow = cmd_idx;
                3'd6: m_rot = 1'b1;
                3'd7: m_rot = 1'b0;
                default: ;
            endcase
        end
        m_isr = nisr & ~clr;
        m_low = nlow;
        for (int i = 0; i < 8; i++) begin
            if (cfg_level) m_irr[i] = 1'b0;
            else if (irq[i] && !m_prev[i]) m_irr[i] = 1'b1;
            else if (fire && w == i) m_irr[i] = 1'b0;
        end
        m_prev = irq;
        if (mask_we) m_mask = mask_wdata;
        @(negedge clk);
        int_ack = 1'b0; poll = 1'b0; cmd_valid = 1'b0; mask_we = 1'b0;
    endtask

    task automatic cmd(input logic [2:0] op, input logic [2:0] idx, input string tag);
        cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx;
        step(tag);
    endtask

    task automatic ack(input string tag);
        int_ack = 1'b1;
        step(tag);
    endtask

    task automatic pulse_irq(input logic [7:0] v, input string tag);
        irq = v; step(tag); irq = '0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL R1 watchdog expired: got hang expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek("R1", 1'b0, 8'h00);
        chk(poll_data, 8'h00, "R1", "poll_data");

        // R2 edge latch survives line drop
        pulse_irq(8'h08, "R2");
        peek("R2", 1'b1, 8'h53);
        step("R2");
        peek("R2", 1'b1, 8'h53);

        // R5/R6 higher source wins, then blocks the lower one
        pulse_irq(8'h02, "R5");
        peek("R5", 1'b1, 8'h51);
        ack("R6");
        peek("R5", 1'b0, 8'h00);

        // R8 non-specific then specific end of interrupt
        cmd(3'd1, 3'd0, "R8");
        peek("R8", 1'b1, 8'h53);
        ack("R6");
        pulse_irq(8'h40, "R5");
        peek("R5", 1'b0, 8'h00);
        cmd(3'd2, 3'd3, "R8");
        peek("R8", 1'b1, 8'h56);
        ack("R6");
        cmd(3'd2, 3'd6, "R8");
        peek("R8", 1'b0, 8'h00);

        // R4 masked request held, served after unmask
        mask_we = 1'b1; mask_wdata = 8'h04;
        pulse_irq(8'h04, "R4");
        step("R4");
        peek("R4", 1'b0, 8'h00);
        mask_we = 1'b1; mask_wdata = 8'h00;
        step("R4");
        peek("R4", 1'b1, 8'h52);
        ack("R4");
        cmd(3'd1, 3'd0, "R8");
        peek("R4", 1'b0, 8'h00);

        // R10 rotation variants
        cmd(3'd5, 3'd4, "R10");
        pulse_irq(8'h44, "R10");
        peek("R10", 1'b1, 8'h56);
        ack("R10");
        peek("R10", 1'b0, 8'h00);
        cmd(3'd3, 3'd0, "R10");
        peek("R10", 1'b1, 8'h52);
        ack("R10");
        cmd(3'd4, 3'd2, "R10");
        pulse_irq(8'h09, "R10");
        peek("R10", 1'b1, 8'h53);
        ack("R10"); cmd(3'd1, 3'd0, "R10");
        ack("R10"); cmd(3'd1, 3'd0, "R10");
        cmd(3'd5, 3'd7, "R10");
        peek("R10", 1'b0, 8'h00);

        // R9 automatic end of interrupt, with rotation
        cfg_auto_eoi = 1'b1;
        pulse_irq(8'h01, "R9");
        ack("R9");
        peek("R9", 1'b0, 8'h00);
        pulse_irq(8'h20, "R9");
        peek("R9", 1'b1, 8'h55);
        cmd(3'd6, 3'd0, "R10");
        ack("R10");
        pulse_irq(8'h41, "R10");
        peek("R10", 1'b1, 8'h56);
        ack("R10"); ack("R10");
        cmd(3'd7, 3'd0, "R10");
        cmd(3'd5, 3'd7, "R10");
        cfg_auto_eoi = 1'b0;

        // R11 special mask mode
        pulse_irq(8'h01, "R11");
        ack("R11");
        pulse_irq(8'h10, "R11");
        peek("R11", 1'b0, 8'h00);
        cfg_special_mask = 1'b1;
        mask_we = 1'b1; mask_wdata = 8'h01;
        step("R11");
        peek("R11", 1'b1, 8'h54);
        ack("R11");
        cfg_special_mask = 1'b0;
        mask_we = 1'b1; mask_wdata = 8'h00;
        step("R11");
        cmd(3'd1, 3'd0, "R8");
        cmd(3'd1, 3'd0, "R8");
        peek("R11", 1'b0, 8'h00);

        // R12 poll word and poll as acknowledge
        #0.2 chk(poll_data, 8'h00, "R12", "poll_data idle");
        pulse_irq(8'h80, "R12");
        #0.2 chk(poll_data, 8'h87, "R12", "poll_data");
        poll = 1'b1; step("R12");
        peek("R12", 1'b0, 8'h00);
        cmd(3'd1, 3'd0, "R8");

        // R7 acknowledge with nothing pending changes nothing
        int_ack = 1'b1; step("R7");
        pulse_irq(8'h80, "R7");
        peek("R7", 1'b1, 8'h57);
        ack("R7"); cmd(3'd1, 3'd0, "R8");

        // R3 level mode follows the line
        cfg_level = 1'b1;
        irq = 8'h10;
        peek("R3", 1'b1, 8'h54);
        step("R3");
        ack("R3");
        peek("R3", 1'b0, 8'h00);
        irq = 8'h00;
        cmd(3'd1, 3'd0, "R3");
        peek("R3", 1'b0, 8'h00);
        irq = 8'h10;
        peek("R3", 1'b1, 8'h54);
        irq = 8'h00;
        cfg_level = 1'b0;
        step("R3");

        // Random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            if (n % 500 == 0) begin
                cfg_level        = ($urandom % 3) == 0;
                cfg_auto_eoi     = ($urandom % 3) == 0;
                cfg_special_mask = ($urandom % 2) == 0;
                cfg_vec_base     = 5'($urandom);
            end
            irq = 8'($urandom & $urandom & $urandom);
            int_ack = ($urandom % 4) == 0;
            poll    = ($urandom % 16) == 0;
            if (($urandom % 6) == 0) begin
                cmd_valid = 1'b1; cmd_op = 3'($urandom); cmd_idx = 3'($urandom);
            end
            if (($urandom % 20) == 0) begin
                mask_we = 1'b1; mask_wdata = 8'($urandom & $urandom);
            end
            step("R5");
        end

        summary();
    end

endmodule